// File: doc/BRIEF.md
# SDRAM write-with-auto-precharge sequencer

This block drives the command, address and data pins of a 16-bit-wide SDRAM for a single write burst of four words. The row closes itself through the auto-precharge flag carried on address bit 10 of the WRITE command. A user port offers one request at a time. Each request holds a bank, a row, a column, four data words and a two-bit byte mask per word. It is taken on a valid/ready handshake, and the whole payload is captured into holding registers in that same clock edge.

After acceptance the block opens the row with ACTIVE and fills the row-to-column delay with NOPs. It then issues WRITE with the auto-precharge flag set and streams the four words, each with its byte mask. Write recovery, precharge time, minimum row-active time and row-cycle time all run hidden inside the device. The sequencer enforces them only as a minimum spacing between one ACTIVE and the next, which it does by holding ready low. Every timing limit is a parameter counted in clock cycles. All pin outputs come straight from registers, and the data bus is released through an output-enable pin whenever no burst word is being driven.

Top module: `sdram_wap_seq`

## Requirements
- R1: While reset is held, req_ready is 1, the command pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), addr and ba are 0, dq_oe is 0, dq_out is 0 and dqm is 2'b11.
- R2: When req_valid and req_ready are both 1 at a rising edge, the next cycle carries ACTIVE (cs_n=0, ras_n=0, cas_n=1, we_n=1) with addr equal to req_row and ba equal to req_bank.
- R3: Exactly T_RCD cycles after the ACTIVE cycle, the pins carry WRITE (cs_n=0, ras_n=1, cas_n=0, we_n=0). In that cycle addr[7:0] is the captured column, addr[10] is 1, addr[11] and addr[9:8] are 0, and ba is the same bank as the ACTIVE.
- R4: dq_oe is 1 in the WRITE cycle and the three cycles after it. In beat k (k=0 in the WRITE cycle), dq_out is req_data[16k+15:16k] and dqm is req_mask[2k+1:2k]. dqm bit 0 covers the low byte, and a 1 blocks that byte.
- R5: In every cycle outside the four burst beats, dq_oe is 0, dq_out is 0 and dqm is 2'b11.
- R6: Every cycle that is neither the ACTIVE nor the WRITE of a request carries NOP, with addr 0 and ba 0.
- R7: req_ready is 0 from the ACTIVE cycle until the cycle GAP-1 after it, and 1 from then on. GAP = max(max(T_RCD+3+T_WR, T_RAS)+T_RP, T_RC), which is 11 with the default parameters. Consecutive ACTIVEs are therefore at least GAP cycles apart, and a request held valid gets its ACTIVE exactly GAP cycles after the previous one.
- R8: req_valid asserted while req_ready is 0 is ignored: no command is issued, and the payload offered then is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | A new ACTIVE may be issued at the next edge |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 12 | Row of the request |
| req_col | input | 8 | Column of the first word |
| req_data | input | 64 | Four data words, word k in bits 16k+15:16k |
| req_mask | input | 8 | Byte masks, word k in bits 2k+1:2k |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 12 | Address pins |
| ba | output | 2 | Bank address pins |
| dq_out | output | 16 | Data to the bus |
| dq_oe | output | 1 | Drive enable for the data bus |
| dqm | output | 2 | Byte masks for the current word |

## Verification
- ACTIVE is due one cycle after the accepting edge.
- WRITE and the first data beat are due T_RCD cycles after ACTIVE, and the last beat three cycles after WRITE.
- ready is due to return GAP-1 cycles after ACTIVE.

The bench's reference model works out these absolute cycle numbers when it accepts a request. It compares every pin against them at the falling edge of each clock, which is half a cycle after the registers have updated. Back-to-back requests and requests offered while blocked check that the ACTIVE-to-ACTIVE spacing is exactly GAP and never less.

// File: rtl/sdram_wap_seq.sv
module sdram_wap_seq #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int DQ_W   = 16,
  parameter int T_RCD  = 3,
  parameter int T_WR   = 2,
  parameter int T_RP   = 3,
  parameter int T_RAS  = 7,
  parameter int T_RC   = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [BANK_W-1:0]         req_bank,
  input  logic [ROW_W-1:0]          req_row,
  input  logic [COL_W-1:0]          req_col,
  input  logic [4*DQ_W-1:0]         req_data,
  input  logic [4*(DQ_W/8)-1:0]     req_mask,
  output logic                      cs_n,
  output logic                      ras_n,
  output logic                      cas_n,
  output logic                      we_n,
  output logic [ROW_W-1:0]          addr,
  output logic [BANK_W-1:0]         ba,
  output logic [DQ_W-1:0]           dq_out,
  output logic                      dq_oe,
  output logic [DQ_W/8-1:0]         dqm
);
  localparam int BURST  = 4;
  localparam int NB     = DQ_W / 8;
  localparam int AP_BIT = 10;
  localparam int L_OFF  = T_RCD + BURST - 1;
  localparam int P_OFF  = (L_OFF + T_WR > T_RAS) ? L_OFF + T_WR : T_RAS;
  localparam int N_A    = P_OFF + T_RP;
  localparam int N_GAP  = (N_A > T_RC) ? N_A : T_RC;
  localparam int CW     = $clog2(N_GAP + 1);

  logic                  busy;
  logic [CW-1:0]         age;
  logic [BANK_W-1:0]     bank_q;
  logic [COL_W-1:0]      col_q;
  logic [4*DQ_W-1:0]     data_q;
  logic [4*NB-1:0]       mask_q;

  wire [CW-1:0]    age_n    = age + 1'b1;
  wire             accept   = req_valid && req_ready;
  wire             in_burst = busy && int'(age_n) >= T_RCD && int'(age_n) < T_RCD + BURST;
  wire [1:0]       beat     = 2'(int'(age_n) - T_RCD);
  wire [ROW_W-1:0] wr_addr  = ROW_W'(col_q) | (ROW_W'(1) << AP_BIT);

  assign req_ready = !busy || age == CW'(N_GAP - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      age    <= '0;
      bank_q <= '0;
      col_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
      cs_n   <= 1'b0;
      ras_n  <= 1'b1;
      cas_n  <= 1'b1;
      we_n   <= 1'b1;
      addr   <= '0;
      ba     <= '0;
      dq_out <= '0;
      dq_oe  <= 1'b0;
      dqm    <= '1;
    end else begin
      cs_n   <= 1'b0;
      ras_n  <= 1'b1;
      cas_n  <= 1'b1;
      we_n   <= 1'b1;
      addr   <= '0;
      ba     <= '0;
      dq_out <= '0;
      dq_oe  <= 1'b0;
      dqm    <= '1;
      if (accept) begin
        busy   <= 1'b1;
        age    <= '0;
        bank_q <= req_bank;
        col_q  <= req_col;
        data_q <= req_data;
        mask_q <= req_mask;
        ras_n  <= 1'b0;
        addr   <= req_row;
        ba     <= req_bank;
      end else if (busy) begin
        age <= age_n;
        if (age == CW'(N_GAP - 1))
          busy <= 1'b0;
        if (int'(age_n) == T_RCD) begin
          cas_n <= 1'b0;
          we_n  <= 1'b0;
          addr  <= wr_addr;
          ba    <= bank_q;
        end
        if (in_burst) begin
          dq_oe  <= 1'b1;
          dq_out <= data_q[int'(beat)*DQ_W +: DQ_W];
          dqm    <= mask_q[int'(beat)*NB +: NB];
        end
      end
    end
  end
endmodule

// File: rtl/sdram_wap_chk.sv
module sdram_wap_chk #(
  parameter int BANK_W = 2,
  parameter int T_RCD  = 3,
  parameter int N_GAP  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              addr_ap,
  input logic [BANK_W-1:0] ba,
  input logic              dq_oe,
  input logic              req_valid,
  input logic              req_ready
);
  wire is_act = !cs_n && !ras_n && cas_n && we_n;
  wire is_wr  = !cs_n && ras_n && !cas_n && !we_n;

  logic [15:0]       since;
  logic              seen;
  logic [BANK_W-1:0] act_bank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since    <= '0;
      seen     <= 1'b0;
      act_bank <= '0;
    end else if (is_act) begin
      since    <= 16'd1;
      seen     <= 1'b1;
      act_bank <= ba;
    end else if (since != '1) begin
      since <= since + 16'd1;
    end
  end

  AST_ACT_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> $past(req_valid && req_ready)); // R2
  AST_WRITE_AUTOPRE: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |-> addr_ap); // R3
  AST_RCD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |-> seen && int'(since) == T_RCD); // R3
  AST_WRITE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |-> ba == act_bank); // R3
  AST_OE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |-> dq_oe); // R4
  AST_OE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> seen && int'(since) >= T_RCD && int'(since) < T_RCD + 4); // R5
  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    is_act && seen |-> int'(since) >= N_GAP); // R7
  AST_BLOCKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> !is_act); // R8
endmodule

bind sdram_wap_seq sdram_wap_chk #(
  .BANK_W(BANK_W), .T_RCD(T_RCD), .N_GAP(N_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .addr_ap(addr[AP_BIT]), .ba(ba), .dq_oe(dq_oe),
  .req_valid(req_valid), .req_ready(req_ready)
);

// File: tb/tb_sdram_wap_seq.sv
module tb_sdram_wap_seq;
  localparam int T_RCD = 3, T_WR = 2, T_RP = 3, T_RAS = 7, T_RC = 10;
  localparam int PA  = (T_RCD + 3 + T_WR > T_RAS) ? T_RCD + 3 + T_WR : T_RAS;
  localparam int GAP = (PA + T_RP > T_RC) ? PA + T_RP : T_RC;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, WR = 4'b0100;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [1:0] req_bank = 0;
  logic [11:0] req_row = 0;
  logic [7:0] req_col = 0, req_mask = 0;
  logic [63:0] req_data = 0;
  logic req_ready, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [11:0] addr;
  logic [1:0] ba, dqm;
  logic [15:0] dq_out;

  always #4 clk = ~clk;

  sdram_wap_seq #(.T_RCD(T_RCD), .T_WR(T_WR), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_data(req_data),
    .req_mask(req_mask), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .dq_out(dq_out), .dq_oe(dq_oe), .dqm(dqm));

  int checks = 0, failures = 0, cyc = 0, nxt = 0, r8_until = -1;
  bit done = 0;
  logic [3:0]  e_cmd [int];
  logic [11:0] e_addr [int];
  logic [1:0]  e_ba [int], e_dqm [int];
  logic [15:0] e_dq [int];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0;
      nxt = 0;
    end else begin
      if (req_valid && cyc >= nxt - 1) begin
        int a, w;
        a = cyc + 1;
        w = a + T_RCD;
        e_cmd[a] = ACT; e_addr[a] = req_row; e_ba[a] = req_bank;
        e_cmd[w] = WR;  e_addr[w] = 12'h400 | {4'h0, req_col}; e_ba[w] = req_bank;
        for (int k = 0; k < 4; k++) begin
          e_dq[w+k]  = req_data[16*k +: 16];
          e_dqm[w+k] = req_mask[2*k +: 2];
        end
        nxt = a + GAP;
      end else if (req_valid) begin
        r8_until = cyc + 2;
      end
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] ec;
      logic [11:0] ea;
      logic [1:0] eb, em;
      logic [15:0] ed;
      bit eo;
      string ct;
      ec = e_cmd.exists(cyc) ? e_cmd[cyc] : NOP;
      ea = e_addr.exists(cyc) ? e_addr[cyc] : 12'h0;
      eb = e_ba.exists(cyc) ? e_ba[cyc] : 2'b0;
      eo = e_dq.exists(cyc);
      ed = eo ? e_dq[cyc] : 16'h0;
      em = eo ? e_dqm[cyc] : 2'b11;
      ct = (ec == ACT) ? "R2" : (ec == WR) ? "R3" : (cyc <= r8_until) ? "R8" : "R6";
      chk({cs_n, ras_n, cas_n, we_n} == ec, ct, "cmd", {cs_n, ras_n, cas_n, we_n}, ec);
      chk(addr == ea, ct, "addr", addr, ea);
      chk(ba == eb, ct, "ba", ba, eb);
      chk(dq_oe == eo, eo ? "R4" : "R5", "dq_oe", dq_oe, eo);
      chk(dq_out == ed, eo ? "R4" : "R5", "dq_out", dq_out, ed);
      chk(dqm == em, eo ? "R4" : "R5", "dqm", dqm, em);
      chk(req_ready == (cyc >= nxt - 1), "R7", "req_ready", req_ready, cyc >= nxt - 1);
    end
  end

  task automatic send(input [1:0] b, input [11:0] r, input [7:0] c, input [63:0] d, input [7:0] m);
    bit got;
    req_valid = 1; req_bank = b; req_row = r; req_col = c; req_data = d; req_mask = m;
    do begin
      got = req_ready;
      @(negedge clk);
    end while (!got);
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the pins
    chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
    chk({cs_n, ras_n, cas_n, we_n} == NOP, "R1", "cmd", {cs_n, ras_n, cas_n, we_n}, NOP);
    chk(addr == 0 && ba == 0, "R1", "addr/ba", {addr, ba}, 0);
    chk(dq_oe == 0 && dq_out == 0, "R1", "dq", {dq_oe, dq_out}, 0);
    chk(dqm == 2'b11, "R1", "dqm", dqm, 3);
    rst_n = 1;
    idle(2);
    send(2'd1, 12'h123, 8'h45, 64'h4444_3333_2222_1111, 8'h00);
    idle(14);
    // R7 back-to-back: second request held valid until ready returns
    send(2'd3, 12'hFFF, 8'hFF, 64'hDEAD_BEEF_CAFE_F00D, 8'b10_01_11_00);
    send(2'd0, 12'h000, 8'h00, 64'h0123_4567_89AB_CDEF, 8'hFF);
    // R8: junk offered while blocked must be ignored
    req_valid = 1; req_bank = 2'd2; req_row = 12'h5A5; req_col = 8'h11;
    req_data = 64'hFFFF_FFFF_FFFF_FFFF; req_mask = 8'h55;
    repeat (3) @(negedge clk);
    idle(14);
    send(2'd2, 12'hA5A, 8'h80, 64'h8001_7FFE_00FF_FF00, 8'b01_10_00_11);
    idle(20);
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
    end
  end
endmodule